// File: doc/BRIEF.md
# Universal Test Sequencer with Response Compaction

This block exercises an AND/XOR testable network with a fixed test sequence. The sequence depends only on the number of data inputs and the number of complemented inputs, never on the function the network computes. After a start request it drives one vector per clock cycle onto a stimulus bus. The bus carries the three control lines, the data lines and the complemented lines. The block samples the main output F and the auxiliary output O at the end of each vector's cycle.

Each output is packed across the whole sequence into one response word. The earliest response sits in the most significant bit. When the sequence ends, both words are compared against golden words, which the block latches from input ports at start. A mismatch in either word raises the detection flag. A pass takes N_DATA+5 cycles and then one report cycle.

The controller has three states. S_IDLE waits and holds the stimulus at zero. S_APPLY presents vector idx and captures the responses. S_REPORT pulses done for one cycle. The transitions are named as follows:
- go: S_IDLE to S_APPLY, taken on start.
- step: S_APPLY to S_APPLY, taken while vectors remain.
- last: S_APPLY to S_REPORT, taken after the final vector.
- ret: S_REPORT to S_IDLE, always taken.

Top module: `tseq_sequencer`

## Requirements
- R1: After reset, done and detected are 0, the stimulus bus is all zero and both response words are 0. The stimulus bus stays zero whenever no pass is running.
- R2: Vector 0, presented in the cycle after start is accepted, drives every stimulus bit to 0.
- R3: Vectors 1, 2 and 3 each drive exactly one control line low, in order c1, c2, c3. Every other bit is 1. Bus layout, MSB first: c1, c2, c3, then x1..xn, then z1..z_nzl.
- R4: Vector 3+k, for k = 1..n, drives data line xk low with every control and all other data lines high.
- R5: Complemented line zj equals data line xj in every vector except the last, vector n+4. In the last vector it is the inverse of xj, so it is 0.
- R6: Each vector lasts exactly one cycle and the pass holds n+5 vectors. done is high for exactly one cycle, the cycle right after the last vector's capture.
- R7: The F response of vector v is bit n+4-v of word_f, so vector 0 lands in the MSB. O is packed the same way into word_o. Both words remain readable until the next start.
- R8: When done is high, detected is 1 exactly when word_f differs from the golden F word or word_o differs from the golden O word. The golden words are taken at start, and later changes on their ports have no effect.
- R9: A start request during a pass is ignored. The pass neither restarts nor extends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted in S_IDLE only) |
| gold_f | input | N_DATA+5 | Fault-free F word, latched at start |
| gold_o | input | N_DATA+5 | Fault-free O word, latched at start |
| stim | output | N_DATA+N_COMP+3 | Control, data and complemented lines toward the network |
| resp_f | input | 1 | Main output F of the network |
| resp_o | input | 1 | Auxiliary output O of the network |
| done | output | 1 | One-cycle pulse ending a pass |
| detected | output | 1 | Fault flag, valid with done and held until next start |
| word_f | output | N_DATA+5 | Packed F responses |
| word_o | output | N_DATA+5 | Packed O responses |

## Verification
The hardest cases to reach from the ports are a response error confined to a single vector at either end of the sequence, and golden or start inputs that change in the middle of a pass. The bench models the network behaviourally and can invert F or O on one chosen vector index. It uses this to place faults on the first vector (the MSB) and on the last vector (the complemented-line vector). Separate passes alter the golden ports and pulse start while vectors are still being applied, then confirm that the report cycle and the verdict are unchanged.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_APPLY  = 2'd1,
        S_REPORT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tseq_vecgen.sv
// Computes the universal test vector selected by idx.
module tseq_vecgen #(
    parameter int N_DATA = 4,
    parameter int N_COMP = 2,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]              idx,
    output logic [N_DATA+N_COMP+3-1:0]    vec
);
    localparam int W    = N_DATA + N_COMP + 3;
    localparam int LAST = N_DATA + 4;

    logic [N_DATA-1:0] data_bits;
    logic              is_last;

    assign is_last = (idx == IDX_W'(LAST));

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_ctrl
            assign vec[W-1-gi] = !((idx == '0) || (idx == IDX_W'(gi + 1)));
        end
        for (gi = 0; gi < N_DATA; gi++) begin : g_data
            assign data_bits[gi]  = !((idx == '0) || (idx == IDX_W'(gi + 4)));
            assign vec[W-4-gi]    = data_bits[gi];
        end
        for (gi = 0; gi < N_COMP; gi++) begin : g_comp
            assign vec[N_COMP-1-gi] = data_bits[gi] ^ is_last;
        end
    endgenerate
endmodule

// File: rtl/tseq_compact.sv
// Shift-in compactor: first sample ends in the MSB.
module tseq_compact #(
    parameter int LEN = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           shift,
    input  logic           din,
    output logic [LEN-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word <= '0;
        else if (clr)   word <= '0;
        else if (shift) word <= {word[LEN-2:0], din};
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !shift) |=> $stable(word));
endmodule

// File: rtl/tseq_sequencer.sv
module tseq_sequencer
    import tseq_pkg::*;
#(
    parameter int N_DATA = 4,
    parameter int N_COMP = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [N_DATA+5-1:0]           gold_f,
    input  logic [N_DATA+5-1:0]           gold_o,
    output logic [N_DATA+N_COMP+3-1:0]    stim,
    input  logic                          resp_f,
    input  logic                          resp_o,
    output logic                          done,
    output logic                          detected,
    output logic [N_DATA+5-1:0]           word_f,
    output logic [N_DATA+5-1:0]           word_o
);
    localparam int W     = N_DATA + N_COMP + 3;
    localparam int NVEC  = N_DATA + 5;
    localparam int LAST  = NVEC - 1;
    localparam int IDX_W = $clog2(NVEC);

    seq_state_t       state, state_nx;
    logic [IDX_W-1:0] idx;
    logic [NVEC-1:0]  gold_f_q, gold_o_q;
    logic             detected_q;
    logic [W-1:0]     vec;
    logic             at_last, accept, shifting;
    logic [1:0]       resp_bits;
    logic [NVEC-1:0]  words [2];
    logic [NVEC-1:0]  next_f, next_o;

    assign at_last  = (idx == IDX_W'(LAST));
    assign accept   = (state == S_IDLE) && start;
    assign shifting = (state == S_APPLY);

    tseq_vecgen #(.N_DATA(N_DATA), .N_COMP(N_COMP), .IDX_W(IDX_W)) u_vec (
        .idx (idx),
        .vec (vec)
    );

    assign resp_bits = {resp_o, resp_f};

    genvar ch;
    generate
        for (ch = 0; ch < 2; ch++) begin : g_cmp
            tseq_compact #(.LEN(NVEC)) u_cmp (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (accept),
                .shift (shifting),
                .din   (resp_bits[ch]),
                .word  (words[ch])
            );
        end
    endgenerate

    assign next_f = {words[0][NVEC-2:0], resp_f};
    assign next_o = {words[1][NVEC-2:0], resp_o};

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_APPLY;            // go
            S_APPLY:  if (at_last) state_nx = S_REPORT;         // last / step
            S_REPORT: state_nx = S_IDLE;                        // ret
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            idx        <= '0;
            gold_f_q   <= '0;
            gold_o_q   <= '0;
            detected_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                idx        <= '0;
                gold_f_q   <= gold_f;
                gold_o_q   <= gold_o;
                detected_q <= 1'b0;
            end else if (shifting) begin
                if (at_last) begin
                    idx        <= '0;
                    detected_q <= (next_f != gold_f_q) || (next_o != gold_o_q);
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        stim     = '0;
        done     = 1'b0;
        unique case (state)
            S_IDLE:   stim = '0;
            S_APPLY:  stim = vec;
            S_REPORT: done = 1'b1;
            default:  stim = '0;
        endcase
        detected = detected_q;
        word_f   = words[0];
        word_o   = words[1];
    end

    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(LAST));
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == S_APPLY && at_last));
    p_ctrl_one_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_APPLY && idx >= IDX_W'(1) && idx <= IDX_W'(3))
            |-> ($countones(stim[W-1:W-3]) == 2));
    p_last_comp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_APPLY && at_last) |-> (stim[N_COMP-1:0] == '0 && stim[W-1:N_COMP] == '1));
    p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_APPLY) |-> (stim == '0));
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_APPLY && !at_last) |=> (state == S_APPLY && idx == $past(idx) + 1'b1));
    p_verdict_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REPORT) |=> $stable(detected));
endmodule

// File: tb/sim_tseq_sequencer.sv
module sim_tseq_sequencer;
    localparam int N  = 4;
    localparam int NC = 2;
    localparam int W  = N + NC + 3;
    localparam int V  = N + 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [V-1:0] gold_f = '0, gold_o = '0;
    logic [W-1:0] stim;
    logic         resp_f, resp_o, done, detected;
    logic [V-1:0] word_f, word_o;

    int checks = 0;
    int errors = 0;
    int cur_v  = -1;
    int flip_f_v = -1;
    int flip_o_v = -1;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // behavioural network model: F over controls, data and complemented lines
    function automatic logic net_f(input logic [W-1:0] s);
        logic c1, c2, c3, x1, x2, x3, x4, z1, z2;
        c1 = s[W-1]; c2 = s[W-2]; c3 = s[W-3];
        x1 = s[W-4]; x2 = s[W-5]; x3 = s[W-6]; x4 = s[W-7];
        z1 = s[NC-1]; z2 = s[NC-2];
        return (c2 & x1) ^ (c3 & x1 & x2) ^ (c1 & z1 & x3) ^ (c2 & x4 & z2) ^ (c3 & ~x2);
    endfunction

    assign resp_f = net_f(stim) ^ (cur_v >= 0 && cur_v == flip_f_v);
    assign resp_o = (^stim) ^ (cur_v >= 0 && cur_v == flip_o_v);

    tseq_sequencer #(.N_DATA(N), .N_COMP(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .gold_f(gold_f), .gold_o(gold_o),
        .stim(stim), .resp_f(resp_f), .resp_o(resp_o), .done(done),
        .detected(detected), .word_f(word_f), .word_o(word_o)
    );

    // expected vector v, built from the requirement text
    function automatic logic [W-1:0] exp_vec(input int v);
        logic [W-1:0] r;
        logic [N-1:0] xs;
        r = '0;
        if (v != 0) begin
            for (int i = 0; i < 3; i++) r[W-1-i] = (v != i + 1);
            for (int k = 1; k <= N; k++) xs[k-1] = (v != 3 + k);
        end else xs = '0;
        for (int k = 1; k <= N; k++) r[W-3-k] = xs[k-1];
        for (int j = 1; j <= NC; j++) r[NC-j] = (v == V - 1) ? ~xs[j-1] : xs[j-1];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [V-1:0] good_f, good_o;

    // one pass; faults on vector index, optional mid-pass start/golden poke
    task automatic run(input logic [V-1:0] gf, input logic [V-1:0] go,
                       input int ff, input int fo, input int poke_at, input int gchg_at);
        logic [V-1:0] ef, eo;
        logic [W-1:0] sv;
        bit edet;
        flip_f_v = ff;
        flip_o_v = fo;
        for (int v = 0; v < V; v++) begin
            sv = exp_vec(v);
            ef[V-1-v] = net_f(sv) ^ (v == ff);
            eo[V-1-v] = (^sv) ^ (v == fo);
        end
        edet = (ef != gf) || (eo != go);
        @(negedge clk);
        gold_f = gf; gold_o = go; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int v = 0; v < V; v++) begin
            if (v > 0) @(negedge clk);
            cur_v = v;
            if (v == poke_at) start = 1'b1;
            else start = 1'b0;
            if (v == gchg_at) begin gold_f = ~gf; gold_o = ~go; end
            // R2 R3 R4 R5: stimulus per vector
            check(stim == exp_vec(v), "R2/R3/R4/R5 stim", 32'(stim), 32'(exp_vec(v)));
            check(done == 1'b0, "R6 done low during pass", 32'(done), 0);
        end
        @(negedge clk);
        start = 1'b0;
        cur_v = -1;
        check(done == 1'b1, "R6 done after last vector", 32'(done), 1);
        check(word_f == ef, "R7 word_f packing", 32'(word_f), 32'(ef));
        check(word_o == eo, "R7 word_o packing", 32'(word_o), 32'(eo));
        check(detected == edet, "R8 detected verdict", 32'(detected), 32'(edet));
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", 32'(done), 0);
        check(stim == '0, "R1 stim idle zero", 32'(stim), 0);
        check(word_f == ef, "R7 word_f held", 32'(word_f), 32'(ef));
        check(detected == edet, "R8 detected held", 32'(detected), 32'(edet));
        gold_f = '0; gold_o = '0;
    endtask

    initial begin
        for (int v = 0; v < V; v++) begin
            good_f[V-1-v] = net_f(exp_vec(v));
            good_o[V-1-v] = ^exp_vec(v);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done", 32'(done), 0);
        check(detected == 1'b0, "R1 detected", 32'(detected), 0);
        check(stim == '0, "R1 stim", 32'(stim), 0);
        check(word_f == '0 && word_o == '0, "R1 words", 32'(word_f), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stim == '0, "R1 idle stim", 32'(stim), 0);

        run(good_f, good_o, -1, -1, -1, -1);   // fault-free: R8 no detection
        run(good_f, good_o, 0, -1, -1, -1);    // R7 F fault on first vector -> MSB
        run(good_f, good_o, -1, V-1, -1, -1);  // O fault on last vector -> LSB
        run(good_f, good_o, -1, -1, -1, 2);    // R8 golden ports changed mid-pass
        run(good_f, good_o, 3, -1, 4, -1);     // R9 start poked mid-pass
        run(good_f ^ 1, good_o, -1, -1, -1, -1); // R8 wrong golden word

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule